// File: doc/BRIEF.md
# Interrupt Recognition Unit

This unit decides, cycle by cycle, whether a simple processor takes a device interrupt. Each device request line is gated by a per-device enable mask to form a set of pending requests. An interrupt is taken only when the global interrupt-enable flag in the status register is set and at least one pending request exists. When several requests are pending together, the lowest-numbered one wins. The unit reports the winner and its handler address, which comes from a computed table of fixed vectors.

When an interrupt is taken, the unit does three things at the clock edge. It copies the whole status register into a saved-status register. It clears the global enable flag, so that no further interrupt is taken until software allows it. It captures the current program counter as the resume address.

A return pulse copies the saved status back into the status register, which also restores the enable flag. Software reaches the status, saved-status, device-enable and pending registers through a single-cycle read/write port. A handler that sets the enable flag again permits nesting. A nested entry overwrites the saved status, so software must keep its own copy of it.

Top module: `irq_recog_unit`

## Requirements
- R1: The pending set equals `dev_req & enable`. It reads back at select 3, in bits `[N_DEV-1:0]` with zeros above, during the same cycle.
- R2: `irq_take` is high in a cycle exactly when status bit 0 (global enable) is 1, the pending set is non-zero and `rti_pulse` is low.
- R3: When `irq_take` is high, `irq_id` is the index of the lowest-numbered pending bit.
- R4: When `irq_take` is high, `handler_pc` equals `VEC_BASE + irq_id * VEC_STRIDE`. The defaults are 0x100 and 0x20.
- R5: After a take, the saved-status register (select 1) holds the status value from the take cycle.
- R6: After a take, status bit 0 is 0 and every other status bit is unchanged.
- R7: After a take, `resume_pc` holds `pc_now` from the take cycle and keeps that value until the next take.
- R8: A cycle with `rti_pulse` high copies saved-status into status at the next edge, and no interrupt is taken in that cycle.
- R9: If software sets bit 0 again inside a handler, a new request is taken. That nested take overwrites saved-status with the current status value.
- R10: A take or a return in the same cycle as a software write to status or saved-status discards that write. A same-cycle write to the enable register still takes effect.
- R11: Reset clears status, saved-status, enable and `resume_pc` to zero.
- R12: The select codes are: 0 for status, 1 for saved-status, 2 for device enable (bits `[N_DEV-1:0]`) and 3 for pending. Pending is read-only, so writes to select 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | N_DEV | Device request lines |
| pc_now | input | AW | Current program counter, captured on a take |
| rti_pulse | input | 1 | Return-from-interrupt strobe |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select |
| csr_wdata | input | DW | Register write data |
| csr_rdata | output | DW | Register read data (combinational) |
| irq_take | output | 1 | Interrupt taken this cycle |
| irq_id | output | IDW | Winning device index |
| handler_pc | output | AW | Handler entry address for the winner |
| resume_pc | output | AW | Saved return address |
| glb_ie | output | 1 | Global interrupt-enable flag |

## Verification
Two things can collide in one cycle, and the bench forces both. The first is a recognition arriving together with a software write. The bench raises a request with the enable flag set while it drives a write to the status register. It then reads back status and saved-status to confirm that the entry values were kept and the write was dropped. It repeats this with a write to the enable register and confirms that this write still lands.

The second collision is a return pulse arriving together with a live enabled request. The bench checks that no take is reported in that cycle and that status afterwards equals the saved value.

// File: rtl/irq_recog_pkg.sv
package irq_recog_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_SAVED   = 2'd1,
    SEL_ENABLE  = 2'd2,
    SEL_PENDING = 2'd3
  } csr_sel_e;

  localparam int IE_BIT = 0;

  // Entry address of the handler for device idx
  function automatic logic [31:0] vec_addr(input logic [31:0] base,
                                           input logic [31:0] stride,
                                           input int unsigned idx);
    return base + stride * idx;
  endfunction

  // Status value after entry: global enable dropped, other bits kept
  function automatic logic [31:0] drop_ie(input logic [31:0] st);
    return st & ~(32'd1 << IE_BIT);
  endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input  logic [N-1:0]   pend,
  output logic           any,
  output logic [IDW-1:0] id
);
  logic [N:0]   seen;
  logic [N-1:0] onehot;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chain
      assign onehot[i]  = pend[i] & ~seen[i];
      assign seen[i+1]  = seen[i] | pend[i];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    id = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) id = IDW'(i);
    end
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int          N          = 8,
  parameter int          IDW        = 3,
  parameter int          AW         = 32,
  parameter logic [31:0] VEC_BASE   = 32'h100,
  parameter logic [31:0] VEC_STRIDE = 32'h20
) (
  input  logic [IDW-1:0] id,
  output logic [AW-1:0]  addr
);
  import irq_recog_pkg::*;

  logic [AW-1:0] tbl [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_vec
      assign tbl[i] = AW'(vec_addr(VEC_BASE, VEC_STRIDE, i));
    end
  endgenerate

  assign addr = tbl[id];
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs #(
  parameter int N_DEV = 8,
  parameter int DW    = 32,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             rti,
  input  logic [AW-1:0]    pc_now,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    status_q,
  output logic [DW-1:0]    saved_q,
  output logic [N_DEV-1:0] enable_q,
  output logic [AW-1:0]    ret_q
);
  import irq_recog_pkg::*;

  logic wr_status, wr_saved, wr_enable;

  assign wr_status = wr_en && (csr_sel_e'(wr_sel) == SEL_STATUS);
  assign wr_saved  = wr_en && (csr_sel_e'(wr_sel) == SEL_SAVED);
  assign wr_enable = wr_en && (csr_sel_e'(wr_sel) == SEL_ENABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      saved_q  <= '0;
      enable_q <= '0;
      ret_q    <= '0;
    end else begin
      // entry and return outrank software writes to the status pair
      if (take) begin
        saved_q  <= status_q;
        status_q <= DW'(drop_ie(32'(status_q)));
        ret_q    <= pc_now;
      end else if (rti) begin
        status_q <= saved_q;
      end else if (wr_status) begin
        status_q <= wr_data;
      end else if (wr_saved) begin
        saved_q  <= wr_data;
      end
      if (wr_enable) enable_q <= wr_data[N_DEV-1:0];
    end
  end
endmodule

// File: rtl/irq_recog_unit.sv
module irq_recog_unit #(
  parameter int          N_DEV      = 8,
  parameter int          DW         = 32,
  parameter int          AW         = 32,
  parameter logic [31:0] VEC_BASE   = 32'h100,
  parameter logic [31:0] VEC_STRIDE = 32'h20,
  localparam int         IDW        = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] dev_req,
  input  logic [AW-1:0]    pc_now,
  input  logic             rti_pulse,
  input  logic             csr_we,
  input  logic [1:0]       csr_sel,
  input  logic [DW-1:0]    csr_wdata,
  output logic [DW-1:0]    csr_rdata,
  output logic             irq_take,
  output logic [IDW-1:0]   irq_id,
  output logic [AW-1:0]    handler_pc,
  output logic [AW-1:0]    resume_pc,
  output logic             glb_ie
);
  import irq_recog_pkg::*;

  logic [DW-1:0]    status_q, saved_q;
  logic [N_DEV-1:0] enable_q;
  logic [N_DEV-1:0] pend_w;
  logic             pend_any;
  logic             ie_w;
  logic             take_w;

  assign pend_w = dev_req & enable_q;
  assign ie_w   = status_q[IE_BIT];
  assign take_w = ie_w & pend_any & ~rti_pulse;

  irq_prio_pick #(.N(N_DEV), .IDW(IDW)) u_pick (
    .pend (pend_w),
    .any  (pend_any),
    .id   (irq_id)
  );

  irq_vec_table #(
    .N(N_DEV), .IDW(IDW), .AW(AW),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_vec (
    .id   (irq_id),
    .addr (handler_pc)
  );

  irq_ctl_regs #(.N_DEV(N_DEV), .DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_w),
    .rti      (rti_pulse),
    .pc_now   (pc_now),
    .wr_en    (csr_we),
    .wr_sel   (csr_sel),
    .wr_data  (csr_wdata),
    .status_q (status_q),
    .saved_q  (saved_q),
    .enable_q (enable_q),
    .ret_q    (resume_pc)
  );

  always_comb begin
    case (csr_sel_e'(csr_sel))
      SEL_STATUS: csr_rdata = status_q;
      SEL_SAVED:  csr_rdata = saved_q;
      SEL_ENABLE: csr_rdata = DW'(enable_q);
      default:    csr_rdata = DW'(pend_w);
    endcase
  end

  assign irq_take = take_w;
  assign glb_ie   = ie_w;
endmodule

// File: rtl/irq_recog_unit_chk.sv
module irq_recog_unit_chk #(
  parameter int          N_DEV      = 8,
  parameter int          DW         = 32,
  parameter int          AW         = 32,
  parameter int          IDW        = 3,
  parameter logic [31:0] VEC_BASE   = 32'h100,
  parameter logic [31:0] VEC_STRIDE = 32'h20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take_w,
  input logic             rti_pulse,
  input logic [IDW-1:0]   irq_id,
  input logic [N_DEV-1:0] pend_w,
  input logic [DW-1:0]    status_q,
  input logic [DW-1:0]    saved_q,
  input logic [AW-1:0]    resume_pc,
  input logic [AW-1:0]    pc_now,
  input logic [AW-1:0]    handler_pc
);
  import irq_recog_pkg::*;

  logic [N_DEV-1:0] below;
  assign below = (N_DEV'(1) << irq_id) - N_DEV'(1);

  a_r2_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (status_q[IE_BIT] && (pend_w != '0) && !rti_pulse));

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (pend_w[irq_id] && ((pend_w & below) == '0)));

  a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (handler_pc == AW'(VEC_BASE + VEC_STRIDE * 32'(irq_id))));

  a_r5_saved_copy: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (saved_q == $past(status_q)));

  a_r6_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> !status_q[IE_BIT]);

  a_r7_resume_addr: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (resume_pc == $past(pc_now)));

  a_r8_rti_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rti_pulse |=> (status_q == $past(saved_q)));
endmodule

bind irq_recog_unit irq_recog_unit_chk #(
  .N_DEV(N_DEV), .DW(DW), .AW(AW), .IDW(IDW),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .take_w     (take_w),
  .rti_pulse  (rti_pulse),
  .irq_id     (irq_id),
  .pend_w     (pend_w),
  .status_q   (status_q),
  .saved_q    (saved_q),
  .resume_pc  (resume_pc),
  .pc_now     (pc_now),
  .handler_pc (handler_pc)
);

// File: tb/irq_recog_unit_bench.sv
module irq_recog_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dev_req = '0;
  logic [31:0] pc_now = '0;
  logic        rti_pulse = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq_take;
  logic [2:0]  irq_id;
  logic [31:0] handler_pc;
  logic [31:0] resume_pc;
  logic        glb_ie;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_recog_unit u_irq_recog_unit (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .pc_now(pc_now),
    .rti_pulse(rti_pulse), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_take(irq_take),
    .irq_id(irq_id), .handler_pc(handler_pc), .resume_pc(resume_pc),
    .glb_ie(glb_ie)
  );

  typedef struct packed {
    logic [7:0] req;
    logic [7:0] en;
    logic       take;
    logic [2:0] id;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h06, 8'h06, 1'b1, 3'd1},
    '{8'h06, 8'h04, 1'b1, 3'd2},
    '{8'hF0, 8'h0F, 1'b0, 3'd0},
    '{8'h81, 8'hFF, 1'b1, 3'd0},
    '{8'h80, 8'h80, 1'b1, 3'd7},
    '{8'h00, 8'hFF, 1'b0, 3'd0},
    '{8'hFF, 8'hFE, 1'b1, 3'd1},
    '{8'h28, 8'h30, 1'b1, 3'd5}
  };

  function automatic logic [31:0] exp_vec(input int idx);
    return 32'h100 + idx * 32'h20;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    csr_sel = s;
    #2;
    v = csr_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd(2'd0, v); chk("R11 status", v, 32'h0);
    rd(2'd1, v); chk("R11 saved", v, 32'h0);
    rd(2'd2, v); chk("R11 enable", v, 32'h0);
    chk("R11 resume_pc", resume_pc, 32'h0);
    chk("R11 take", {31'd0, irq_take}, 32'h0);

    // R1 R2 R3 R4: vector table walk
    for (int k = 0; k < 8; k++) begin
      wr(2'd2, {24'd0, VECS[k].en});
      wr(2'd0, 32'h1);
      dev_req = VECS[k].req;
      #2;
      chk("R2 take", {31'd0, irq_take}, {31'd0, VECS[k].take});
      if (VECS[k].take) begin
        chk("R3 id", {29'd0, irq_id}, {29'd0, VECS[k].id});
        chk("R4 handler", handler_pc, exp_vec(int'(VECS[k].id)));
      end
      rd(2'd3, v); chk("R1 pending", v, {24'd0, VECS[k].req & VECS[k].en});
      @(negedge clk);
      dev_req = '0;
    end

    // R2: global enable off blocks a pending request
    wr(2'd2, 32'hFF);
    wr(2'd0, 32'h0);
    dev_req = 8'h01;
    #2;
    chk("R2 ie=0 no take", {31'd0, irq_take}, 32'h0);
    rd(2'd3, v); chk("R1 pending ie=0", v, 32'h1);
    @(negedge clk);
    dev_req = '0;

    // R5 R6 R7: entry
    wr(2'd0, 32'hA1);
    pc_now = 32'h1234;
    dev_req = 8'h04;
    #2;
    chk("R2 entry take", {31'd0, irq_take}, 32'h1);
    chk("R4 entry handler", handler_pc, 32'h140);
    @(negedge clk);
    dev_req = '0;
    pc_now = 32'h9999;
    rd(2'd0, v); chk("R6 status after entry", v, 32'hA0);
    rd(2'd1, v); chk("R5 saved after entry", v, 32'hA1);
    chk("R7 resume", resume_pc, 32'h1234);
    @(negedge clk);
    chk("R7 resume held", resume_pc, 32'h1234);

    // R9: nested re-enable
    wr(2'd0, 32'hA3);
    pc_now = 32'h2000;
    dev_req = 8'h01;
    #2;
    chk("R9 nested take", {31'd0, irq_take}, 32'h1);
    chk("R9 nested id", {29'd0, irq_id}, 32'h0);
    @(negedge clk);
    dev_req = '0;
    rd(2'd1, v); chk("R9 saved overwritten", v, 32'hA3);
    rd(2'd0, v); chk("R9 status", v, 32'hA2);
    chk("R9 resume", resume_pc, 32'h2000);

    // R8: return restores status
    rti_pulse = 1'b1;
    @(negedge clk);
    rti_pulse = 1'b0;
    rd(2'd0, v); chk("R8 restore", v, 32'hA3);

    // R8: return cycle blocks a live enabled request
    @(negedge clk);
    dev_req = 8'h01;
    rti_pulse = 1'b1;
    #2;
    chk("R8 no take on rti", {31'd0, irq_take}, 32'h0);
    @(negedge clk);
    rti_pulse = 1'b0;
    dev_req = '0;
    rd(2'd0, v); chk("R8 status after rti", v, 32'hA3);

    // R10: entry beats a same-cycle status write
    @(negedge clk);
    csr_we = 1'b1; csr_sel = 2'd0; csr_wdata = 32'h55;
    dev_req = 8'h02;
    #2;
    chk("R10 take with write", {31'd0, irq_take}, 32'h1);
    @(negedge clk);
    csr_we = 1'b0;
    dev_req = '0;
    rd(2'd0, v); chk("R10 status write dropped", v, 32'hA2);
    rd(2'd1, v); chk("R10 saved", v, 32'hA3);

    // R10: enable write lands even on an entry cycle
    wr(2'd0, 32'h1);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = 32'h0;
    dev_req = 8'h08;
    #2;
    chk("R10 take id", {29'd0, irq_id}, 32'h3);
    @(negedge clk);
    csr_we = 1'b0;
    dev_req = '0;
    rd(2'd2, v); chk("R10 enable written", v, 32'h0);
    rd(2'd0, v); chk("R6 ie cleared", v, 32'h0);

    // R12: pending is read-only
    wr(2'd2, 32'h0F);
    wr(2'd3, 32'hFF);
    rd(2'd3, v); chk("R12 pending unwritten", v, 32'h0);
    rd(2'd2, v); chk("R12 enable unchanged", v, 32'h0F);
    dev_req = 8'hFF;
    rd(2'd3, v); chk("R1 pending masked", v, 32'h0F);
    chk("R2 masked no take", {31'd0, irq_take}, 32'h0);
    @(negedge clk);
    dev_req = '0;

    finish_run();
  end
endmodule